// File: doc/BRIEF.md
# Clock-Sampled Write-Only Serial Register File

This block receives configuration writes for a two-channel tone generator over a four-wire serial link in mode 0. The serial clock is never used to clock flip-flops. Chip select, serial clock and data are passed through two-flop synchronisers into the system clock domain. A rising edge of the synchronised serial clock is detected there, and the data bit is sampled on that edge. The serial clock must therefore run at no more than one eighth of the system clock.

Each transfer is sixteen bits, most significant bit first. A command byte comes first, and its low nibble is the register address. A data byte follows. The sixteenth bit commits the write. A select that changes early drops the transfer. Bits that follow the sixteenth are discarded until select is released. The stored fields drive the downstream tone channels, levels and envelope directly as registered outputs. Two one-cycle strobes are also produced: one for a register clear and one for an envelope restart.

The reset input is asynchronous and active low, and it takes effect at once. Release passes through a two-stage pipeline, so the logic comes out of reset two clocks after the input goes high.

Top module: `spiwr_regfile`

## Requirements
- R1: While rst_n is low, every output holds its reset value without waiting for a clock edge. The reset values are: audio_en 0; note_a and note_b 7'h0F (octave 0, tone code 15, the no-tone range); all channel control fields 0; both volumes 0; env_mode, env_apply_a and env_apply_b 0; env_period 8'h10; both strobes 0. Internal reset ends two clock edges after rst_n rises, and a frame that starts after that is received.
- R2: A frame is 16 data bits, most significant bit first. Each bit is sampled from MOSI at a rising edge of the synchronised serial clock while CS_N is low. Bits [11:8] of the frame are the address and bits [7:0] are the data. Command bits [15:12] are not decoded.
- R3: Fields are placed as follows:
  - Address 0: bit 0 is audio_en.
  - Addresses 1 and 3: data bits [6:4] are the octave and [3:0] the tone code, giving note_a and note_b as data[6:0]. Bit 7 is dropped.
  - Addresses 2 (channel A) and 4 (channel B): bits [1:0] are the waveform, bit 2 is tone enable, bit 4 is envelope enable and bit 5 is the gate.
  - Address 5: vol_a is data[2:0] and vol_b is data[6:4].
  - Address 7: bit 0 is env_mode, bit 3 is env_apply_a and bit 4 is env_apply_b.
  - Address 8: env_period is data[7:0]. The value 0 is stored as 0.
- R4: A complete frame to address 6 or to addresses 9 through 15 changes no output.
- R5: If CS_N rises before the sixteenth bit, nothing is written.
- R6: Serial clock edges after the sixteenth bit are ignored until CS_N goes high. The first data byte stays in effect.
- R7: A write to address 0 with data bit 1 set raises clr_pulse for exactly one cycle. On the next clock, every stored field returns to its R1 reset value, including the audio_en bit carried by that same write.
- R8: A write to address 7 with data bit 2 set raises env_restart for exactly one cycle. Bit 2 is not stored, and a write to address 7 with bit 2 clear produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, sampled as data |
| spi_mosi | input | 1 | Serial data in |
| audio_en | output | 1 | Audio enable |
| clr_pulse | output | 1 | One-cycle register clear strobe |
| note_a | output | 7 | Channel A octave [6:4] and tone code [3:0] |
| chan_a_wave | output | 2 | Channel A waveform select |
| chan_a_tone_en | output | 1 | Channel A tone enable |
| chan_a_env_en | output | 1 | Channel A envelope enable |
| chan_a_gate | output | 1 | Channel A gate |
| note_b | output | 7 | Channel B octave [6:4] and tone code [3:0] |
| chan_b_wave | output | 2 | Channel B waveform select |
| chan_b_tone_en | output | 1 | Channel B tone enable |
| chan_b_env_en | output | 1 | Channel B envelope enable |
| chan_b_gate | output | 1 | Channel B gate |
| vol_a | output | 3 | Channel A level |
| vol_b | output | 3 | Channel B level |
| env_mode | output | 1 | Envelope shape select |
| env_apply_a | output | 1 | Apply envelope to channel A |
| env_apply_b | output | 1 | Apply envelope to channel B |
| env_restart | output | 1 | One-cycle envelope restart strobe |
| env_period | output | 8 | Envelope step period |

## Verification
The hardest case to produce is a frame that is abandoned part way through. Only a correct bit counter tells a 15-bit burst or an over-long burst apart from a proper frame. The bench reaches it with a bit-level sender that can stop after any number of bits or keep clocking past sixteen. After each case it compares every output against a model kept in the bench. The clear strobe's one-cycle lifetime and its effect on the next clock are covered by counting strobe cycles on the falling clock edge and then comparing the full output set against the reset values.

// File: rtl/spiwr_pkg.sv
package spiwr_pkg;
  localparam int CMD_W  = 8;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic [2:0] octave;
    logic [3:0] tone;
  } note_t;

  typedef struct packed {
    logic       gate;
    logic       env_en;
    logic       tone_en;
    logic [1:0] wave;
  } chan_ctl_t;

  localparam note_t           NOTE_RST   = '{octave: 3'd0, tone: 4'hF};
  localparam chan_ctl_t       CHAN_RST   = '0;
  localparam logic [DATA_W-1:0] PERIOD_RST = 8'h10;

  localparam logic [ADDR_W-1:0] ADR_MAIN  = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_VOL   = 4'h5;
  localparam logic [ADDR_W-1:0] ADR_ENV   = 4'h7;
  localparam logic [ADDR_W-1:0] ADR_STEP  = 4'h8;

  localparam int BIT_CLEAR   = 1;
  localparam int BIT_RESTART = 2;
endpackage

// File: rtl/spiwr_sync.sv
module spiwr_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spiwr_frame.sv
module spiwr_frame
  import spiwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              mosi_s,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int SH_W    = ADDR_W + DATA_W - 1;

  logic             sck_d, cs_d, done;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  shreg;
  logic             sck_rise, cs_edge;

  assign sck_rise = sck_s & ~sck_d;
  assign cs_edge  = cs_n_s ^ cs_d;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sck_d    <= 1'b0;
      cs_d     <= 1'b1;
      done     <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      sck_d    <= sck_s;
      cs_d     <= cs_n_s;
      wr_valid <= 1'b0;
      if (cs_n_s || cs_edge) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (sck_rise && !done) begin
        shreg <= {shreg[SH_W-2:0], mosi_s};
        if (cnt == CNT_W'(FRAME_W - 1)) begin
          cnt      <= '0;
          done     <= 1'b1;
          wr_valid <= 1'b1;
          wr_addr  <= shreg[SH_W-1:DATA_W-1];
          wr_data  <= {shreg[DATA_W-2:0], mosi_s};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spiwr_regmap.sv
module spiwr_regmap
  import spiwr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_valid,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic                   audio_en,
  output logic                   clr_pulse,
  output note_t     [NUM_CH-1:0] note_q,
  output chan_ctl_t [NUM_CH-1:0] chan_q,
  output logic      [2:0]        vol_a,
  output logic      [2:0]        vol_b,
  output logic                   env_mode,
  output logic                   env_apply_a,
  output logic                   env_apply_b,
  output logic                   env_restart,
  output logic      [DATA_W-1:0] env_period
);
  logic hit_main, hit_vol, hit_env, hit_step;

  assign hit_main = wr_valid && (wr_addr == ADR_MAIN);
  assign hit_vol  = wr_valid && (wr_addr == ADR_VOL);
  assign hit_env  = wr_valid && (wr_addr == ADR_ENV);
  assign hit_step = wr_valid && (wr_addr == ADR_STEP);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      audio_en    <= 1'b0;
      clr_pulse   <= 1'b0;
      env_restart <= 1'b0;
      vol_a       <= '0;
      vol_b       <= '0;
      env_mode    <= 1'b0;
      env_apply_a <= 1'b0;
      env_apply_b <= 1'b0;
      env_period  <= PERIOD_RST;
    end else begin
      clr_pulse   <= hit_main && wr_data[BIT_CLEAR] && !clr_pulse;
      env_restart <= hit_env && wr_data[BIT_RESTART] && !clr_pulse;
      if (clr_pulse) begin
        audio_en    <= 1'b0;
        vol_a       <= '0;
        vol_b       <= '0;
        env_mode    <= 1'b0;
        env_apply_a <= 1'b0;
        env_apply_b <= 1'b0;
        env_period  <= PERIOD_RST;
      end else begin
        if (hit_main) audio_en <= wr_data[0];
        if (hit_vol) begin
          vol_a <= wr_data[2:0];
          vol_b <= wr_data[6:4];
        end
        if (hit_env) begin
          env_mode    <= wr_data[0];
          env_apply_a <= wr_data[3];
          env_apply_b <= wr_data[4];
        end
        if (hit_step) env_period <= wr_data;
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam logic [ADDR_W-1:0] ADR_NOTE = ADDR_W'(1 + 2 * ch);
    localparam logic [ADDR_W-1:0] ADR_CTL  = ADDR_W'(2 + 2 * ch);

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        note_q[ch] <= NOTE_RST;
        chan_q[ch] <= CHAN_RST;
      end else if (clr_pulse) begin
        note_q[ch] <= NOTE_RST;
        chan_q[ch] <= CHAN_RST;
      end else if (wr_valid) begin
        if (wr_addr == ADR_NOTE) note_q[ch] <= note_t'(wr_data[6:0]);
        if (wr_addr == ADR_CTL)
          chan_q[ch] <= '{gate: wr_data[5], env_en: wr_data[4],
                          tone_en: wr_data[2], wave: wr_data[1:0]};
      end
    end
  end
endmodule

// File: rtl/spiwr_regfile.sv
module spiwr_regfile
  import spiwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  output logic       audio_en,
  output logic       clr_pulse,
  output logic [6:0] note_a,
  output logic [1:0] chan_a_wave,
  output logic       chan_a_tone_en,
  output logic       chan_a_env_en,
  output logic       chan_a_gate,
  output logic [6:0] note_b,
  output logic [1:0] chan_b_wave,
  output logic       chan_b_tone_en,
  output logic       chan_b_env_en,
  output logic       chan_b_gate,
  output logic [2:0] vol_a,
  output logic [2:0] vol_b,
  output logic       env_mode,
  output logic       env_apply_a,
  output logic       env_apply_b,
  output logic       env_restart,
  output logic [7:0] env_period
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int = ~rst_pipe[RST_STAGES-1];

  logic [2:0] sync_q;
  logic       cs_n_s, sck_s, mosi_s;

  spiwr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) sync_i (
    .clk (clk),
    .rst (rst_int),
    .d   ({spi_mosi, spi_sck, spi_cs_n}),
    .q   (sync_q)
  );
  assign {mosi_s, sck_s, cs_n_s} = sync_q;

  logic              wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  spiwr_frame frame_i (
    .clk      (clk),
    .rst      (rst_int),
    .cs_n_s   (cs_n_s),
    .sck_s    (sck_s),
    .mosi_s   (mosi_s),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  note_t     [NUM_CH-1:0] note_q;
  chan_ctl_t [NUM_CH-1:0] chan_q;

  spiwr_regmap regmap_i (
    .clk         (clk),
    .rst         (rst_int),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .audio_en    (audio_en),
    .clr_pulse   (clr_pulse),
    .note_q      (note_q),
    .chan_q      (chan_q),
    .vol_a       (vol_a),
    .vol_b       (vol_b),
    .env_mode    (env_mode),
    .env_apply_a (env_apply_a),
    .env_apply_b (env_apply_b),
    .env_restart (env_restart),
    .env_period  (env_period)
  );

  assign note_a         = note_q[0];
  assign chan_a_wave    = chan_q[0].wave;
  assign chan_a_tone_en = chan_q[0].tone_en;
  assign chan_a_env_en  = chan_q[0].env_en;
  assign chan_a_gate    = chan_q[0].gate;
  assign note_b         = note_q[1];
  assign chan_b_wave    = chan_q[1].wave;
  assign chan_b_tone_en = chan_q[1].tone_en;
  assign chan_b_env_en  = chan_q[1].env_en;
  assign chan_b_gate    = chan_q[1].gate;
endmodule

// File: rtl/spiwr_regfile_chk.sv
module spiwr_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_int,
  input logic        cs_n_s,
  input logic        wr_valid,
  input logic        clr_pulse,
  input logic        env_restart,
  input logic [41:0] regs
);
  localparam logic [41:0] REGS_RST =
    {1'b0, 7'h0F, 5'b0, 7'h0F, 5'b0, 3'b0, 3'b0, 3'b0, 8'h10};

  // R1: internal reset ends once rst_n has been seen high on two edges
  a_r1_release_two_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && $past(rst_n, 2)) |-> !rst_int);

  // R2: a write is only committed while the synchronised select is low
  a_r2_write_inside_frame: assert property (@(posedge clk) disable iff (rst_int)
    wr_valid |-> !cs_n_s);

  // R4, R5: stored fields move only after a committed write or a clear
  a_r5_hold_without_write: assert property (@(posedge clk) disable iff (rst_int)
    (!wr_valid && !clr_pulse) |=> $stable(regs));

  // R7: the clear strobe lasts one cycle
  a_r7_clear_one_cycle: assert property (@(posedge clk) disable iff (rst_int)
    clr_pulse |=> !clr_pulse);

  // R7: the cycle after the strobe every field holds its reset value
  a_r7_clear_restores: assert property (@(posedge clk) disable iff (rst_int)
    clr_pulse |=> (regs == REGS_RST));

  // R8: the restart strobe lasts one cycle
  a_r8_restart_one_cycle: assert property (@(posedge clk) disable iff (rst_int)
    env_restart |=> !env_restart);
endmodule

bind spiwr_regfile spiwr_regfile_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_int     (rst_int),
  .cs_n_s      (cs_n_s),
  .wr_valid    (wr_valid),
  .clr_pulse   (clr_pulse),
  .env_restart (env_restart),
  .regs        ({audio_en, note_a, chan_a_gate, chan_a_env_en, chan_a_tone_en,
                 chan_a_wave, note_b, chan_b_gate, chan_b_env_en, chan_b_tone_en,
                 chan_b_wave, vol_a, vol_b, env_mode, env_apply_a, env_apply_b,
                 env_period})
);

// File: tb/spiwr_regfile_tb_top.sv
module spiwr_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 6;
  localparam int NV         = 16;

  // {addr[3:0], data[7:0], expected field view[7:0]}
  localparam logic [19:0] VEC [NV] = '{
    {4'h0, 8'h01, 8'h01}, {4'h0, 8'hFD, 8'h01}, {4'h1, 8'hB6, 8'h36},
    {4'h2, 8'hFF, 8'h37}, {4'h3, 8'h49, 8'h49}, {4'h4, 8'h2B, 8'h23},
    {4'h5, 8'hFF, 8'h77}, {4'h5, 8'h8D, 8'h05}, {4'h7, 8'h1B, 8'h19},
    {4'h8, 8'h00, 8'h00}, {4'h8, 8'hA5, 8'hA5}, {4'h6, 8'hFF, 8'h00},
    {4'h9, 8'h55, 8'h00}, {4'hF, 8'hAA, 8'h00}, {4'h7, 8'h00, 8'h00},
    {4'h2, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_n = 1'b0, spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic audio_en, clr_pulse, env_restart, env_mode, env_apply_a, env_apply_b;
  logic [6:0] note_a, note_b;
  logic [1:0] chan_a_wave, chan_b_wave;
  logic chan_a_tone_en, chan_a_env_en, chan_a_gate;
  logic chan_b_tone_en, chan_b_env_en, chan_b_gate;
  logic [2:0] vol_a, vol_b;
  logic [7:0] env_period;

  spiwr_regfile dut_i (.*);

  int checks = 0, fails = 0, clr_cnt = 0, rs_cnt = 0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (clr_pulse) clr_cnt++;
    if (env_restart) rs_cnt++;
  end

  // bench model of the register map
  logic m_audio, m_mode, m_app_a, m_app_b;
  logic [6:0] m_note_a, m_note_b;
  logic [4:0] m_ctl_a, m_ctl_b;
  logic [2:0] m_vol_a, m_vol_b;
  logic [7:0] m_per;

  task automatic model_reset();
    m_audio = 0; m_note_a = 7'h0F; m_note_b = 7'h0F; m_ctl_a = 0; m_ctl_b = 0;
    m_vol_a = 0; m_vol_b = 0; m_mode = 0; m_app_a = 0; m_app_b = 0; m_per = 8'h10;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    case (a)
      4'h0: begin m_audio = d[0]; if (d[1]) model_reset(); end
      4'h1: m_note_a = d[6:0];
      4'h2: m_ctl_a = {d[5], d[4], d[2], d[1:0]};
      4'h3: m_note_b = d[6:0];
      4'h4: m_ctl_b = {d[5], d[4], d[2], d[1:0]};
      4'h5: begin m_vol_a = d[2:0]; m_vol_b = d[6:4]; end
      4'h7: begin m_mode = d[0]; m_app_a = d[3]; m_app_b = d[4]; end
      4'h8: m_per = d;
      default: ;
    endcase
  endtask

  function automatic logic [41:0] snap();
    return {audio_en, note_a, chan_a_gate, chan_a_env_en, chan_a_tone_en, chan_a_wave,
            note_b, chan_b_gate, chan_b_env_en, chan_b_tone_en, chan_b_wave,
            vol_a, vol_b, env_mode, env_apply_a, env_apply_b, env_period};
  endfunction

  function automatic logic [41:0] model_snap();
    return {m_audio, m_note_a, m_ctl_a, m_note_b, m_ctl_b, m_vol_a, m_vol_b,
            m_mode, m_app_a, m_app_b, m_per};
  endfunction

  function automatic logic [7:0] view(input logic [3:0] a);
    case (a)
      4'h0: return {7'b0, audio_en};
      4'h1: return {1'b0, note_a};
      4'h2: return {2'b0, chan_a_gate, chan_a_env_en, 1'b0, chan_a_tone_en, chan_a_wave};
      4'h3: return {1'b0, note_b};
      4'h4: return {2'b0, chan_b_gate, chan_b_env_en, 1'b0, chan_b_tone_en, chan_b_wave};
      4'h5: return {1'b0, vol_b, 1'b0, vol_a};
      4'h7: return {3'b0, env_apply_b, env_apply_a, 2'b0, env_mode};
      4'h8: return env_period;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends the low n bits of w, most significant first, in one select window
  task automatic spi_send(input logic [31:0] w, input int n);
    spi_cs_n = 1'b0;
    clks(HALF_SCK);
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = w[i];
      clks(HALF_SCK);
      spi_sck = 1'b1;
      clks(HALF_SCK);
      spi_sck = 1'b0;
    end
    clks(HALF_SCK);
    spi_cs_n = 1'b1;
    clks(HALF_SCK + 6);
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
    spi_send({16'h0, 4'h0, a, d}, 16);
    model_write(a, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    model_reset();
    clks(5);
    rst_n = 1'b1;
    clks(4);
    // R1: reset values after start-up
    check("R1 reset values", 48'(snap()), 48'(model_snap()));
    check("R1 strobes idle", {46'b0, clr_pulse, env_restart}, 48'h0);

    // R3 / R4: vector walk
    for (int i = 0; i < NV; i++) begin
      logic [3:0] a;
      string rq;
      a = VEC[i][19:16];
      rq = (a == 4'h6 || a > 4'h8) ? "R4 ignored address" : "R3 field map";
      write_reg(a, VEC[i][15:8]);
      check(rq, 48'(view(a)), 48'(VEC[i][7:0]));
      check(rq, 48'(snap()), 48'(model_snap()));
    end
    // R7 / R8: no strobe from the walk (no clear bit at address 0, no restart bit at 7)
    check("R7 no clear without bit1", 48'(clr_cnt), 48'd0);
    check("R8 no restart without bit2", 48'(rs_cnt), 48'd0);

    // R2: command upper nibble not decoded
    spi_send({16'h0, 8'hA3, 8'h12}, 16);
    model_write(4'h3, 8'h12);
    check("R2 upper nibble ignored", 48'(note_b), 48'h12);

    // R5: aborted frames
    write_reg(4'h1, 8'h21);
    spi_send(32'h0833 >> 1, 15);
    check("R5 15-bit frame dropped", 48'(snap()), 48'(model_snap()));
    spi_send(32'h01, 8);
    check("R5 8-bit frame dropped", 48'(snap()), 48'(model_snap()));

    // R6: trailing bits ignored
    spi_send({8'h0, 8'h01, 8'h5A, 8'hFF}, 24);
    model_write(4'h1, 8'h5A);
    check("R6 extra bits ignored", 48'(note_a), 48'h5A);
    check("R6 other fields", 48'(snap()), 48'(model_snap()));

    // R8: restart strobe
    c0 = rs_cnt;
    write_reg(4'h7, 8'h04);
    check("R8 restart one cycle", 48'(rs_cnt - c0), 48'd1);
    check("R8 restart not stored", 48'(view(4'h7)), 48'h00);

    // R7: clear
    write_reg(4'h5, 8'h33);
    write_reg(4'h8, 8'h7E);
    c0 = clr_cnt;
    write_reg(4'h0, 8'h03);
    check("R7 clear one cycle", 48'(clr_cnt - c0), 48'd1);
    check("R7 all reset", 48'(snap()), 48'(model_snap()));
    check("R7 audio_en from same write", 48'(audio_en), 48'd0);

    // R1: asynchronous assertion and release
    write_reg(4'h3, 8'h45);
    write_reg(4'h0, 8'h01);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    model_reset();
    check("R1 immediate reset", 48'(snap()), 48'(model_snap()));
    clks(3);
    rst_n = 1'b1;
    write_reg(4'h4, 8'h35);
    check("R1 frame after release", 48'(snap()), 48'(model_snap()));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule